// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, frame by frame, whether a received Ethernet frame should be kept. It looks only at the 48-bit destination address. It sorts the frame into one of three classes: broadcast, multicast or unicast. It then applies a small set of static control bits and a single station-address entry that software programs through a narrow register port. For every frame the block reports a keep/drop verdict, the class, and a reason code that says why a frame was dropped.

The receive logic presents the destination address together with a one-cycle valid strobe, and the address is captured on that clock edge. One cycle later the block raises `resultValid`, and the verdict for the captured address is available on the outputs. The verdict is formed combinationally from the captured address, the live control bits and the stored station entry.

Software reaches three locations through the register port:

- The high address word holds the first four address bytes.
- The low address word holds the last two address bytes.
- The entry-enable word keeps a single bit.

Top module: `mac_dest_filter`

## Requirements
- R1: `frameClass` is 2 (broadcast) when all 48 captured address bits are one. It is 1 (multicast) when the group bit `destAddr[40]` (bit 0 of the first byte, which sits in `destAddr[47:40]`) is one and the frame is not broadcast. Otherwise it is 0 (unicast).
- R2: A broadcast frame is kept when `cfgComplement` is one. Otherwise it is kept only when `cfgAcceptBcast` is one, and it is dropped with reason 1 when that bit is zero.
- R3: A multicast frame is kept when `cfgComplement` is one. Otherwise it is kept only when `cfgAcceptMcast` is one, and it is dropped with reason 2 when that bit is zero.
- R4: A unicast frame is kept, with reason 0, whenever `cfgAcceptAllUcast` is one, whatever the station entry and the other bits hold.
- R5: Otherwise a unicast frame hits when three things hold: `cfgCompareEn` is one, the entry-enable bit is one, and all six address bytes equal the stored station bytes. Without complement a hit is kept and a miss is dropped with reason 3. With `cfgComplement` a miss is kept and a hit is dropped with reason 4.
- R6: A write with `regSel`=0 loads station bytes 0, 1, 2 and 3 from `regWrData[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Reading `regSel`=0 returns them in the same places. Byte 0 is compared against `destAddr[47:40]`.
- R7: A write with `regSel`=1 loads station bytes 4 and 5 from `regWrData[31:24]` and `[23:16]`. Reading `regSel`=1 returns them there, with bits 15:0 reading as zero.
- R8: A write with `regSel`=2 keeps only `regWrData[0]` as the entry-enable bit. Reading `regSel`=2 returns that bit in bit 0 and zero in bits 31:1. A write with `regSel`=3 changes no stored state, and `regSel`=3 reads as zero.
- R9: `reason` takes one of these values: 0 (kept), 1 (broadcast disabled), 2 (multicast disabled), 3 (unicast mismatch) or 4 (complemented hit). `accept` is one exactly when `reason` is 0.
- R10: `resultValid` is one in the cycle after a cycle with `frameValid` high, and zero otherwise. The verdict refers to the address captured on that edge. After reset `resultValid` is zero, the station bytes are zero and the enable bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | Destination address present this cycle |
| destAddr | input | 48 | Destination address, first byte in bits 47:40 |
| cfgComplement | input | 1 | Complement-compare mode |
| cfgAcceptBcast | input | 1 | Keep broadcast frames |
| cfgAcceptMcast | input | 1 | Keep multicast frames |
| cfgAcceptAllUcast | input | 1 | Keep every unicast frame |
| cfgCompareEn | input | 1 | Enable station-address compare |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 high word, 1 low word, 2 enable, 3 none |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the selected register |
| resultValid | output | 1 | Verdict valid for the captured address |
| accept | output | 1 | Frame is kept |
| reason | output | 3 | Verdict reason code |
| frameClass | output | 2 | 0 unicast, 1 multicast, 2 broadcast |

## Verification
The bench builds the filter with its default parameters: a 32-bit register word and a 6-byte address. This means the high word carries four station bytes and the low word carries two. The bench sweeps all 32 combinations of the control bits, with the entry enabled and then disabled. In each combination it sends a broadcast address, a multicast address, an exact unicast hit, and unicast misses that differ only in the first byte or only in the last byte. This places a single-lane mismatch at both ends of the byte order. Register writes with stray bits, a write to the unused select, and gaps in the frame strobe exercise the register-port rules and the one-cycle result timing.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2
  } frameClassE;

  typedef enum logic [2:0] {
    RSN_KEEP       = 3'd0,
    RSN_BCAST_OFF  = 3'd1,
    RSN_MCAST_OFF  = 3'd2,
    RSN_UCAST_MISS = 3'd3,
    RSN_CMPL_HIT   = 3'd4
  } reasonE;

  typedef enum logic [1:0] {
    SEL_HI   = 2'd0,
    SEL_LO   = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } regSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic ldHi;
    logic ldLo;
    logic ldEn;
    logic capture;
  } strobeT;

endpackage

// File: rtl/mdf_ctrl.sv
module mdf_ctrl
  import mdf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameValid,
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  output strobeT     stb,
  output logic       resultValid
);

  always_comb begin
    stb         = '0;
    stb.capture = frameValid;
    if (regWrEn) begin
      unique case (regSel)
        SEL_HI:  stb.ldHi = 1'b1;
        SEL_LO:  stb.ldLo = 1'b1;
        SEL_EN:  stb.ldEn = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= frameValid;
  end

  // R10
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> resultValid);

  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> !resultValid);

  // R8
  sel_none_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_NONE) |-> !(stb.ldHi || stb.ldLo || stb.ldEn));

endmodule

// File: rtl/mdf_datapath.sv
module mdf_datapath
  import mdf_pkg::*;
#(
  parameter int unsigned REG_W      = 32,
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  stb,
  input  logic [8*ADDR_BYTES-1:0] destAddr,
  input  logic [REG_W-1:0]        regWrData,
  input  logic [1:0]              regSel,
  input  logic                    cfgComplement,
  input  logic                    cfgAcceptBcast,
  input  logic                    cfgAcceptMcast,
  input  logic                    cfgAcceptAllUcast,
  input  logic                    cfgCompareEn,
  output logic [REG_W-1:0]        regRdData,
  output logic                    accept,
  output logic [2:0]              reason,
  output logic [1:0]              frameClass
);

  localparam int unsigned ADDR_W   = 8 * ADDR_BYTES;
  localparam int unsigned BPR      = REG_W / 8;
  localparam int unsigned LO_BYTES = ADDR_BYTES - BPR;

  logic [ADDR_W-1:0]     stationAddr;
  logic [ADDR_W-1:0]     capAddr;
  logic [ADDR_BYTES-1:0] byteHit;
  logic                  entryEn;

  // one register and one comparator per station byte
  for (genvar i = 0; i < ADDR_BYTES; i++) begin : gByte
    logic [7:0] byteQ;
    if (i < BPR) begin : gHi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         byteQ <= '0;
        else if (stb.ldHi) byteQ <= regWrData[REG_W-1-8*i -: 8];
      end
    end else begin : gLo
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         byteQ <= '0;
        else if (stb.ldLo) byteQ <= regWrData[REG_W-1-8*(i-BPR) -: 8];
      end
    end
    assign stationAddr[ADDR_W-1-8*i -: 8] = byteQ;
    assign byteHit[i] = (byteQ == capAddr[ADDR_W-1-8*i -: 8]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         entryEn <= 1'b0;
    else if (stb.ldEn) entryEn <= regWrData[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            capAddr <= '0;
    else if (stb.capture) capAddr <= destAddr;
  end

  // register read mux
  logic [REG_W-1:0] hiRd, loRd;
  always_comb begin
    hiRd = '0;
    loRd = '0;
    for (int i = 0; i < BPR; i++)
      hiRd[REG_W-1-8*i -: 8] = stationAddr[ADDR_W-1-8*i -: 8];
    for (int j = 0; j < LO_BYTES; j++)
      loRd[REG_W-1-8*j -: 8] = stationAddr[ADDR_W-1-8*(BPR+j) -: 8];
  end

  always_comb begin
    unique case (regSel)
      SEL_HI:  regRdData = hiRd;
      SEL_LO:  regRdData = loRd;
      SEL_EN:  regRdData = {{(REG_W-1){1'b0}}, entryEn};
      default: regRdData = '0;
    endcase
  end

  // classification and verdict
  logic isBcast, isMcast, ucastHit;
  assign isBcast  = &capAddr;
  assign isMcast  = capAddr[ADDR_W-8] & ~isBcast;
  assign ucastHit = cfgCompareEn & entryEn & (&byteHit);

  reasonE rsn;
  always_comb begin
    if (isBcast) begin
      frameClass = CLS_BCAST;
      rsn = (cfgComplement || cfgAcceptBcast) ? RSN_KEEP : RSN_BCAST_OFF;
    end else if (isMcast) begin
      frameClass = CLS_MCAST;
      rsn = (cfgComplement || cfgAcceptMcast) ? RSN_KEEP : RSN_MCAST_OFF;
    end else begin
      frameClass = CLS_UCAST;
      if (cfgAcceptAllUcast)  rsn = RSN_KEEP;
      else if (cfgComplement) rsn = ucastHit ? RSN_CMPL_HIT : RSN_KEEP;
      else                    rsn = ucastHit ? RSN_KEEP : RSN_UCAST_MISS;
    end
  end

  assign reason = rsn;
  assign accept = (rsn == RSN_KEEP);

  // R6
  hi_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldHi |=> stationAddr[ADDR_W-1 -: REG_W] == $past(regWrData));

  // R7
  lo_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldLo |=> stationAddr[8*LO_BYTES-1:0] == $past(regWrData[REG_W-1 -: 8*LO_BYTES]));

  // R8
  en_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_EN) |-> (regRdData[REG_W-1:1] == '0));

  // R2
  bcast_cmpl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameClass == CLS_BCAST && cfgComplement) |-> accept);

  // R3
  mcast_cmpl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameClass == CLS_MCAST && cfgComplement) |-> accept);

  // R1
  mcast_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameClass == CLS_MCAST) |-> (capAddr[ADDR_W-8] && !(&capAddr)));

  // R5
  ucast_nocmp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameClass == CLS_UCAST && !cfgAcceptAllUcast && !cfgComplement && !cfgCompareEn)
      |-> !accept);

endmodule

// File: rtl/mac_dest_filter.sv
module mac_dest_filter
  import mdf_pkg::*;
#(
  parameter int unsigned REG_W      = 32,
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameValid,
  input  logic [8*ADDR_BYTES-1:0] destAddr,
  input  logic                    cfgComplement,
  input  logic                    cfgAcceptBcast,
  input  logic                    cfgAcceptMcast,
  input  logic                    cfgAcceptAllUcast,
  input  logic                    cfgCompareEn,
  input  logic                    regWrEn,
  input  logic [1:0]              regSel,
  input  logic [REG_W-1:0]        regWrData,
  output logic [REG_W-1:0]        regRdData,
  output logic                    resultValid,
  output logic                    accept,
  output logic [2:0]              reason,
  output logic [1:0]              frameClass
);

  strobeT stb;

  mdf_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameValid  (frameValid),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .stb         (stb),
    .resultValid (resultValid)
  );

  mdf_datapath #(
    .REG_W      (REG_W),
    .ADDR_BYTES (ADDR_BYTES)
  ) u_dp (
    .clk               (clk),
    .rstN              (rstN),
    .stb               (stb),
    .destAddr          (destAddr),
    .regWrData         (regWrData),
    .regSel            (regSel),
    .cfgComplement     (cfgComplement),
    .cfgAcceptBcast    (cfgAcceptBcast),
    .cfgAcceptMcast    (cfgAcceptMcast),
    .cfgAcceptAllUcast (cfgAcceptAllUcast),
    .cfgCompareEn      (cfgCompareEn),
    .regRdData         (regRdData),
    .accept            (accept),
    .reason            (reason),
    .frameClass        (frameClass)
  );

  // R9
  keep_means_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (reason == 3'd0));

endmodule

// File: tb/mac_dest_filter_bench.sv
`timescale 1ns/1ps
module mac_dest_filter_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameValid;
  logic [47:0] destAddr;
  logic        cfgComplement, cfgAcceptBcast, cfgAcceptMcast, cfgAcceptAllUcast, cfgCompareEn;
  logic        regWrEn;
  logic [1:0]  regSel;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        resultValid, accept;
  logic [2:0]  reason;
  logic [1:0]  frameClass;

  always #5 clk = ~clk;

  mac_dest_filter u_mac_dest_filter (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .destAddr(destAddr),
    .cfgComplement(cfgComplement), .cfgAcceptBcast(cfgAcceptBcast),
    .cfgAcceptMcast(cfgAcceptMcast), .cfgAcceptAllUcast(cfgAcceptAllUcast),
    .cfgCompareEn(cfgCompareEn), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .resultValid(resultValid),
    .accept(accept), .reason(reason), .frameClass(frameClass)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  byte unsigned mStation[6];
  bit           mEn;
  logic [47:0]  mCap;
  bit           mValid;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint expRead(input int sel);
    case (sel)
      0: return (longint'(mStation[0]) << 24) | (longint'(mStation[1]) << 16) |
                (longint'(mStation[2]) << 8) | longint'(mStation[3]);
      1: return (longint'(mStation[4]) << 24) | (longint'(mStation[5]) << 16);
      2: return longint'(mEn);
      default: return 0;
    endcase
  endfunction

  function automatic string readTag(input int sel);
    case (sel)
      0: return "R6";
      1: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic compareNow();
    int cls, rsn;
    string tag;
    bit hit;
    chk(resultValid == mValid, "R10 resultValid", resultValid, mValid);
    chk(regRdData == 32'(expRead(int'(regSel))), readTag(int'(regSel)), regRdData, expRead(int'(regSel)));
    if (mValid) begin
      if (mCap == 48'hFFFF_FFFF_FFFF) begin
        cls = 2; tag = "R2";
        rsn = (cfgComplement || cfgAcceptBcast) ? 0 : 1;
      end else if (mCap[40]) begin
        cls = 1; tag = "R3";
        rsn = (cfgComplement || cfgAcceptMcast) ? 0 : 2;
      end else begin
        cls = 0;
        if (cfgAcceptAllUcast) begin
          tag = "R4"; rsn = 0;
        end else begin
          tag = "R5";
          hit = cfgCompareEn && mEn;
          for (int k = 0; k < 6; k++)
            if (mCap[47-8*k -: 8] != mStation[k]) hit = 0;
          if (cfgComplement) rsn = hit ? 4 : 0;
          else               rsn = hit ? 0 : 3;
        end
      end
      chk(frameClass == 2'(cls), "R1 class", frameClass, cls);
      chk(accept == (rsn == 0), {tag, " accept"}, accept, (rsn == 0));
      chk(reason == 3'(rsn), {"R9 reason ", tag}, reason, rsn);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit fv, input logic [47:0] da, input bit we,
                     input logic [1:0] sel, input logic [31:0] wd);
    frameValid = fv; destAddr = da; regWrEn = we; regSel = sel; regWrData = wd;
    @(posedge clk);
    if (we) begin
      case (sel)
        2'd0: for (int k = 0; k < 4; k++) mStation[k] = wd[31-8*k -: 8];
        2'd1: begin mStation[4] = wd[31:24]; mStation[5] = wd[23:16]; end
        2'd2: mEn = wd[0];
        default: ;
      endcase
    end
    if (fv) mCap = da;
    mValid = fv;
    @(negedge clk);
    compareNow();
  endtask

  task automatic setCfg(input int c);
    cfgComplement     = c[0];
    cfgAcceptBcast    = c[1];
    cfgAcceptMcast    = c[2];
    cfgAcceptAllUcast = c[3];
    cfgCompareEn      = c[4];
  endtask

  localparam logic [47:0] BCAST  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCAST  = 48'h0100_5E00_0001;
  localparam logic [47:0] HIT    = 48'h02A1_B2C3_D4E5;
  localparam logic [47:0] MISS_L = 48'h02A1_B2C3_D4E6;
  localparam logic [47:0] MISS_F = 48'h06A1_B2C3_D4E5;

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    setCfg(0);
    frameValid = 0; destAddr = '0; regWrEn = 0; regSel = 0; regWrData = '0;
    for (int k = 0; k < 6; k++) mStation[k] = 0;
    mEn = 0; mCap = '0; mValid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state, R10
    for (int s = 0; s < 4; s++) begin
      regSel = 2'(s);
      #1;
      chk(regRdData == 32'h0, "R10 reset readback", regRdData, 0);
    end
    chk(resultValid == 1'b0, "R10 reset valid", resultValid, 0);
    rstN = 1'b1;

    // register port: R6 R7 R8
    cyc(0, '0, 1, 2'd0, 32'h02A1_B2C3);
    cyc(0, '0, 1, 2'd1, 32'hD4E5_7777);
    cyc(0, '0, 1, 2'd2, 32'hFFFF_FFFF);
    cyc(0, '0, 1, 2'd2, 32'hFFFF_FFFE);
    cyc(0, '0, 1, 2'd2, 32'h0000_0001);
    cyc(0, '0, 1, 2'd3, 32'hDEAD_BEEF);    // R8 ignored select
    cyc(0, '0, 0, 2'd0, 32'h0);
    cyc(0, '0, 0, 2'd1, 32'h0);
    cyc(0, '0, 0, 2'd2, 32'h0);

    // decision sweep, entry enabled then disabled
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) cyc(0, '0, 1, 2'd2, 32'h0);
      for (int c = 0; c < 32; c++) begin
        setCfg(c);
        cyc(1, BCAST,  0, 2'(c % 3), 32'h0);
        cyc(1, MCAST,  0, 2'(c % 3), 32'h0);
        cyc(1, HIT,    0, 2'(c % 3), 32'h0);
        cyc(0, MISS_F, 0, 2'(c % 3), 32'h0);   // gap: no capture
        cyc(1, MISS_L, 0, 2'(c % 3), 32'h0);
        cyc(1, MISS_F, 0, 2'(c % 3), 32'h0);
      end
    end

    // reprogram station while frames flow
    setCfg(16);
    cyc(0, '0, 1, 2'd2, 32'h1);
    cyc(1, HIT, 1, 2'd0, 32'h06A1_B2C3);
    cyc(1, MISS_F, 0, 2'd0, 32'h0);
    cyc(1, HIT, 0, 2'd1, 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule